// File: doc/BRIEF.md
# Dual-Clock Adjustable 64-bit Timer

This block is a memory-mapped 64-bit free-running counter with a 32-bit register bus. It advances on a fast reference tick and also counts a slow always-on tick. An input flag, `fast_off`, marks the intervals when the fast reference is stopped and only the slow tick runs. After such an interval the count can be brought back in line in one of two ways. The hardware can do it from two programmed ratio constants, or software can add a 64-bit delta of its own.

Three modes are selected in the control register. Normal mode only counts. In hard-adjust mode the hardware corrects the count when the fast tick returns. In soft-adjust mode a sync-request write adds the software delta. The slow-tick counter value is captured at the start and at the end of every fast-off interval, and a valid bit is kept for each capture. Interrupt status bits are write-one-to-clear, and one level interrupt output is qualified by an enable mask.

Top module: `adjtmr_top`

## Requirements
- R1: After reset the count reads 0, the status reads 0, `irq` is low, both load words read 0xFFFFFFFF, the fast ratio reads 0xB71B and the slow ratio reads 0x40.
- R2: Control register (offset 0x00) bit 0 is the enable and bits [2:1] are the mode (0 normal, 1 hard-adjust, 2 soft-adjust). While the block is disabled, the count is held at 0. While it is enabled, each `fast_tick` that arrives with `fast_off` low adds 1.
- R3: Reading the count low word (0x14) latches the high word. A later read of 0x18 returns that latched high word, even if the count has carried in between.
- R4: Status bit 0 is set while the block is enabled and the count equals the 64-bit load value (0x0C low, 0x10 high).
- R5: `irq` is high exactly when some status bit (0x08) is set and its enable bit (0x04) is set. Bit 0 is count reached, bit 1 is hard-adjust done and bit 2 is sync done.
- R6: Writing 1 to a status bit clears it. If a set event occurs in the same cycle, the set wins.
- R7: In soft-adjust mode, writing 1 to the sync register (0x24) adds the delta (0x1C low, 0x20 high) to the count and sets status bit 2.
- R8: Outside soft-adjust mode, a sync write leaves the count unchanged and does not set status bit 2.
- R9: In hard-adjust mode, while `fast_off` is high, the count is frozen and each `slow_tick` adds the fast ratio (0x28) to an internal accumulator.
- R10: In hard-adjust mode, the first `fast_tick` after `fast_off` falls adds the accumulator shifted right by floor(log2(slow ratio, 0x2C)) in place of the usual +1, and sets status bit 1.
- R11: The slow-tick counter is copied into the begin stamp (0x30/0x34) when `fast_off` rises and into the end stamp (0x38/0x3C) when it falls. Each capture sets its bit in 0x40 (bit 0 begin, bit 1 end), and writing 1s to 0x40 clears those bits.
- R12: Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; data appears on `rdata` after the next edge |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| fast_tick | input | 1 | Fast reference tick strobe |
| slow_tick | input | 1 | Slow always-on tick strobe |
| fast_off | input | 1 | High while the fast reference is stopped |
| irq | output | 1 | Level interrupt |

## Verification
The hardest case to reach is the hard-adjust handback. It needs a fast-off interval with slow ticks inside it, then the first fast tick after the interval ends, and the exact shifted amount has to appear in the count at that point. The bench builds this case in order: it counts a few fast ticks, raises `fast_off`, sends a stray fast tick (which must be ignored) and three slow ticks, drops `fast_off`, and reads the count both before and after one further fast tick. The bench reaches the coherent high-word read by using soft-adjust deltas to park the count just below a 32-bit carry.

// File: rtl/adjtmr_pkg.sv
package adjtmr_pkg;
    localparam int DW     = 32;
    localparam int CW     = 2 * DW;
    localparam int AW     = 8;
    localparam int NEV    = 3;
    localparam int SHW    = $clog2(DW);

    localparam int EV_REACH = 0;
    localparam int EV_ADJ   = 1;
    localparam int EV_SYNC  = 2;

    localparam logic [AW-1:0] OFF_CTRL    = 8'h00;
    localparam logic [AW-1:0] OFF_IEN     = 8'h04;
    localparam logic [AW-1:0] OFF_STAT    = 8'h08;
    localparam logic [AW-1:0] OFF_LOAD_LO = 8'h0C;
    localparam logic [AW-1:0] OFF_LOAD_HI = 8'h10;
    localparam logic [AW-1:0] OFF_CNT_LO  = 8'h14;
    localparam logic [AW-1:0] OFF_CNT_HI  = 8'h18;
    localparam logic [AW-1:0] OFF_DLT_LO  = 8'h1C;
    localparam logic [AW-1:0] OFF_DLT_HI  = 8'h20;
    localparam logic [AW-1:0] OFF_SYNC    = 8'h24;
    localparam logic [AW-1:0] OFF_FRATIO  = 8'h28;
    localparam logic [AW-1:0] OFF_SRATIO  = 8'h2C;
    localparam logic [AW-1:0] OFF_BEG_LO  = 8'h30;
    localparam logic [AW-1:0] OFF_BEG_HI  = 8'h34;
    localparam logic [AW-1:0] OFF_END_LO  = 8'h38;
    localparam logic [AW-1:0] OFF_END_HI  = 8'h3C;
    localparam logic [AW-1:0] OFF_VALID   = 8'h40;

    typedef enum logic [1:0] {
        MODE_NORM = 2'd0,
        MODE_HARD = 2'd1,
        MODE_SOFT = 2'd2,
        MODE_RSVD = 2'd3
    } mode_e;

    typedef struct packed {
        mode_e mode;
        logic  en;
    } ctrl_t;

    // Position of the highest set bit; 0 for a zero input.
    function automatic logic [SHW-1:0] msb_index(input logic [DW-1:0] v);
        logic [SHW-1:0] r;
        r = '0;
        for (int i = 0; i < DW; i++)
            if (v[i]) r = SHW'(i);
        return r;
    endfunction
endpackage

// File: rtl/adjtmr_regs.sv
module adjtmr_regs
    import adjtmr_pkg::*;
#(
    parameter logic [DW-1:0] FRATIO_RST = 32'h0000_B71B,
    parameter logic [DW-1:0] SRATIO_RST = 32'h0000_0040
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic           rd_en,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  wdata,
    output logic [DW-1:0]  rdata,
    input  logic [CW-1:0]  count,
    input  logic [CW-1:0]  t_begin,
    input  logic [CW-1:0]  t_end,
    input  logic [1:0]     valid,
    input  logic [NEV-1:0] evt,
    output ctrl_t          ctrl,
    output logic [NEV-1:0] ien,
    output logic [NEV-1:0] stat,
    output logic [CW-1:0]  load,
    output logic [CW-1:0]  delta,
    output logic [DW-1:0]  fratio,
    output logic [DW-1:0]  sratio,
    output logic           sync,
    output logic [1:0]     valid_clr
);
    logic [DW-1:0]  hi_shadow;
    logic [DW-1:0]  rmux;
    logic [NEV-1:0] stat_clr;

    assign sync      = wr_en && (addr == OFF_SYNC) && wdata[0];
    assign valid_clr = (wr_en && (addr == OFF_VALID)) ? wdata[1:0] : 2'b00;
    assign stat_clr  = (wr_en && (addr == OFF_STAT)) ? wdata[NEV-1:0] : '0;

    always_comb begin
        case (addr)
            OFF_CTRL:    rmux = DW'(ctrl);
            OFF_IEN:     rmux = DW'(ien);
            OFF_STAT:    rmux = DW'(stat);
            OFF_LOAD_LO: rmux = load[DW-1:0];
            OFF_LOAD_HI: rmux = load[CW-1:DW];
            OFF_CNT_LO:  rmux = count[DW-1:0];
            OFF_CNT_HI:  rmux = hi_shadow;
            OFF_DLT_LO:  rmux = delta[DW-1:0];
            OFF_DLT_HI:  rmux = delta[CW-1:DW];
            OFF_FRATIO:  rmux = fratio;
            OFF_SRATIO:  rmux = sratio;
            OFF_BEG_LO:  rmux = t_begin[DW-1:0];
            OFF_BEG_HI:  rmux = t_begin[CW-1:DW];
            OFF_END_LO:  rmux = t_end[DW-1:0];
            OFF_END_HI:  rmux = t_end[CW-1:DW];
            OFF_VALID:   rmux = DW'(valid);
            default:     rmux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= '0;
            ien       <= '0;
            stat      <= '0;
            load      <= '1;
            delta     <= '0;
            fratio    <= FRATIO_RST;
            sratio    <= SRATIO_RST;
            hi_shadow <= '0;
            rdata     <= '0;
        end else begin
            if (wr_en) begin
                case (addr)
                    OFF_CTRL:    ctrl            <= ctrl_t'(wdata[2:0]);
                    OFF_IEN:     ien             <= wdata[NEV-1:0];
                    OFF_LOAD_LO: load[DW-1:0]    <= wdata;
                    OFF_LOAD_HI: load[CW-1:DW]   <= wdata;
                    OFF_DLT_LO:  delta[DW-1:0]   <= wdata;
                    OFF_DLT_HI:  delta[CW-1:DW]  <= wdata;
                    OFF_FRATIO:  fratio          <= wdata;
                    OFF_SRATIO:  sratio          <= wdata;
                    default: ;
                endcase
            end
            stat <= (stat & ~stat_clr) | evt;
            if (rd_en) begin
                rdata <= rmux;
                if (addr == OFF_CNT_LO)
                    hi_shadow <= count[CW-1:DW];
            end
        end
    end

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == OFF_STAT && wdata[EV_SYNC] && !evt[EV_SYNC]) |=> !stat[EV_SYNC]); // R6
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        evt[EV_REACH] |=> stat[EV_REACH]); // R6
endmodule

// File: rtl/adjtmr_core.sv
module adjtmr_core
    import adjtmr_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  ctrl_t          ctrl,
    input  logic           fast_tick,
    input  logic           fast_off,
    input  logic           slow_tick,
    input  logic           sync,
    input  logic [CW-1:0]  load,
    input  logic [CW-1:0]  delta,
    input  logic [DW-1:0]  fratio,
    input  logic [DW-1:0]  sratio,
    output logic [CW-1:0]  count,
    output logic [NEV-1:0] evt
);
    logic [CW-1:0] acc_q;
    logic          owed_q;
    logic          is_hard, is_soft, run_tick, apply, soft_sync;

    assign is_hard   = (ctrl.mode == MODE_HARD);
    assign is_soft   = (ctrl.mode == MODE_SOFT);
    assign run_tick  = fast_tick && !fast_off;
    assign apply     = is_hard && owed_q && run_tick;
    assign soft_sync = is_soft && sync;

    assign evt[EV_REACH] = ctrl.en && (count == load);
    assign evt[EV_ADJ]   = ctrl.en && apply;
    assign evt[EV_SYNC]  = ctrl.en && soft_sync;

    always_ff @(posedge clk) begin
        if (rst || !ctrl.en) begin
            count  <= '0;
            acc_q  <= '0;
            owed_q <= 1'b0;
        end else begin
            if (is_hard && fast_off) begin
                owed_q <= 1'b1;
                if (slow_tick)
                    acc_q <= acc_q + CW'(fratio);
            end
            if (apply) begin
                count  <= count + (acc_q >> msb_index(sratio));
                acc_q  <= '0;
                owed_q <= 1'b0;
            end else begin
                count <= count + CW'(run_tick) + (soft_sync ? delta : '0);
            end
        end
    end

    AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (rst)
        !ctrl.en |=> (count == '0)); // R2
    AST_FROZEN_WHILE_OFF: assert property (@(posedge clk) disable iff (rst)
        (ctrl.en && fast_off && !soft_sync) |=> (count == $past(count))); // R9
    AST_SYNC_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (ctrl.en && !is_soft && sync && !fast_tick) |=> (count == $past(count))); // R8
endmodule

// File: rtl/adjtmr_stamp.sv
module adjtmr_stamp
    import adjtmr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          fast_off,
    input  logic          slow_tick,
    input  logic [1:0]    valid_clr,
    output logic [CW-1:0] t_begin,
    output logic [CW-1:0] t_end,
    output logic [1:0]    valid
);
    logic [CW-1:0] slow_q;
    logic          was_off;
    logic [1:0]    cap;

    assign cap[0] = en && fast_off && !was_off;
    assign cap[1] = en && !fast_off && was_off;

    always_ff @(posedge clk) begin
        if (rst) begin
            slow_q  <= '0;
            was_off <= 1'b0;
            t_begin <= '0;
            t_end   <= '0;
            valid   <= '0;
        end else begin
            was_off <= fast_off;
            if (!en)
                slow_q <= '0;
            else if (slow_tick)
                slow_q <= slow_q + 1'b1;
            if (cap[0]) t_begin <= slow_q;
            if (cap[1]) t_end   <= slow_q;
            valid <= (valid & ~valid_clr) | cap;
        end
    end

    AST_BEGIN_CAPTURED: assert property (@(posedge clk) disable iff (rst)
        (en && fast_off && !was_off) |=> valid[0]); // R11
    AST_END_CAPTURED: assert property (@(posedge clk) disable iff (rst)
        (en && !fast_off && was_off) |=> (valid[1] && t_end == $past(slow_q))); // R11
endmodule

// File: rtl/adjtmr_top.sv
module adjtmr_top
    import adjtmr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [7:0]    addr,
    input  logic [31:0]   wdata,
    output logic [31:0]   rdata,
    input  logic          fast_tick,
    input  logic          slow_tick,
    input  logic          fast_off,
    output logic          irq
);
    ctrl_t          ctrl;
    logic [NEV-1:0] ien, stat, evt;
    logic [CW-1:0]  load, delta, count, t_begin, t_end;
    logic [DW-1:0]  fratio, sratio;
    logic           sync;
    logic [1:0]     valid, valid_clr;

    adjtmr_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .count(count), .t_begin(t_begin),
        .t_end(t_end), .valid(valid), .evt(evt), .ctrl(ctrl), .ien(ien),
        .stat(stat), .load(load), .delta(delta), .fratio(fratio),
        .sratio(sratio), .sync(sync), .valid_clr(valid_clr)
    );

    adjtmr_core u_core (
        .clk(clk), .rst(rst), .ctrl(ctrl), .fast_tick(fast_tick),
        .fast_off(fast_off), .slow_tick(slow_tick), .sync(sync), .load(load),
        .delta(delta), .fratio(fratio), .sratio(sratio), .count(count), .evt(evt)
    );

    adjtmr_stamp u_stamp (
        .clk(clk), .rst(rst), .en(ctrl.en), .fast_off(fast_off),
        .slow_tick(slow_tick), .valid_clr(valid_clr), .t_begin(t_begin),
        .t_end(t_end), .valid(valid)
    );

    assign irq = |(stat & ien);
endmodule

// File: tb/adjtmr_top_test.sv
module adjtmr_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        fast_tick = 1'b0, slow_tick = 1'b0, fast_off = 1'b0;
    logic        irq;
    int          checks = 0;
    int          errors = 0;

    always #5 clk = ~clk;

    adjtmr_top uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .fast_tick(fast_tick),
        .slow_tick(slow_tick), .fast_off(fast_off), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0; v = rdata;
    endtask

    task automatic ftick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); fast_tick = 1'b1;
            @(negedge clk); fast_tick = 1'b0;
        end
    endtask

    task automatic stick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); slow_tick = 1'b1;
            @(negedge clk); slow_tick = 1'b0;
        end
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(8'h14, v); check("R1 count", v, 0);
        rd(8'h08, v); check("R1 status", v, 0);
        check("R1 irq", {31'b0, irq}, 0);
        rd(8'h0C, v); check("R1 load lo", v, 32'hFFFF_FFFF);
        rd(8'h10, v); check("R1 load hi", v, 32'hFFFF_FFFF);
        rd(8'h28, v); check("R1 fast ratio", v, 32'hB71B);
        rd(8'h2C, v); check("R1 slow ratio", v, 32'h40);
    endtask

    task automatic t_count;
        logic [31:0] v;
        ftick(2);
        rd(8'h14, v); check("R2 disabled holds 0", v, 0);
        wr(8'h00, 32'h1);
        ftick(7);
        rd(8'h14, v); check("R2 count lo", v, 7);
        rd(8'h18, v); check("R2 count hi", v, 0);
        @(negedge clk); fast_off = 1'b1; fast_tick = 1'b1;
        @(negedge clk); fast_tick = 1'b0; fast_off = 1'b0;
        rd(8'h14, v); check("R2 tick ignored while fast_off", v, 7);
        wr(8'h00, 32'h0);
        rd(8'h14, v); check("R2 disable clears", v, 0);
        wr(8'h40, 32'h3);
    endtask

    task automatic t_reach;
        logic [31:0] v;
        wr(8'h0C, 32'd4); wr(8'h10, 32'd0);
        wr(8'h04, 32'h1);
        wr(8'h00, 32'h1);
        ftick(3);
        rd(8'h08, v); check("R4 not yet reached", v, 0);
        check("R5 irq low", {31'b0, irq}, 0);
        ftick(1);
        rd(8'h08, v); check("R4 reached", v, 1);
        check("R5 irq high", {31'b0, irq}, 1);
        wr(8'h04, 32'h0);
        check("R5 irq masked", {31'b0, irq}, 0);
        wr(8'h04, 32'h1);
        wr(8'h08, 32'h1);
        rd(8'h08, v); check("R6 set wins over clear", v, 1);
        ftick(1);
        wr(8'h08, 32'h1);
        rd(8'h08, v); check("R6 w1c clears", v, 0);
        check("R5 irq after clear", {31'b0, irq}, 0);
        wr(8'h0C, 32'hFFFF_FFFF); wr(8'h10, 32'hFFFF_FFFF);
    endtask

    task automatic t_sync_ignored;
        logic [31:0] v;
        wr(8'h1C, 32'd100);
        wr(8'h24, 32'h1);
        rd(8'h14, v); check("R8 count unchanged", v, 5);
        rd(8'h08, v); check("R8 no sync status", v & 32'h4, 0);
    endtask

    task automatic t_soft;
        logic [31:0] v;
        wr(8'h00, 32'h0);
        wr(8'h08, 32'h7);
        wr(8'h00, 32'h5);
        ftick(3);
        wr(8'h1C, 32'h10); wr(8'h20, 32'h1);
        wr(8'h24, 32'h1);
        rd(8'h14, v); check("R7 soft lo", v, 32'h13);
        rd(8'h18, v); check("R7 soft hi", v, 32'h1);
        rd(8'h08, v); check("R7 sync status", v & 32'h4, 32'h4);
        wr(8'h1C, 32'hFFFF_FFEB); wr(8'h20, 32'h0);
        wr(8'h24, 32'h1);
        rd(8'h14, v); check("R3 lo before carry", v, 32'hFFFF_FFFE);
        ftick(2);
        rd(8'h18, v); check("R3 latched hi", v, 32'h1);
        rd(8'h14, v); check("R3 lo after carry", v, 32'h0);
        rd(8'h18, v); check("R3 new hi", v, 32'h2);
    endtask

    task automatic t_hard;
        logic [31:0] v;
        wr(8'h00, 32'h0);
        wr(8'h08, 32'h7);
        wr(8'h40, 32'h3);
        wr(8'h00, 32'h3);
        ftick(5);
        @(negedge clk); fast_off = 1'b1;
        ftick(1);
        stick(3);
        @(negedge clk); fast_off = 1'b0;
        @(negedge clk);
        rd(8'h14, v); check("R9 frozen count", v, 5);
        rd(8'h08, v); check("R10 not done yet", v & 32'h2, 0);
        rd(8'h30, v); check("R11 begin", v, 0);
        rd(8'h38, v); check("R11 end", v, 3);
        rd(8'h40, v); check("R11 valid", v, 3);
        ftick(1);
        rd(8'h14, v); check("R10 adjusted lo", v, 5 + (3 * 32'hB71B) / 64);
        rd(8'h18, v); check("R10 adjusted hi", v, 0);
        rd(8'h08, v); check("R10 adj done", v & 32'h2, 32'h2);
        ftick(1);
        rd(8'h14, v); check("R10 resumes +1", v, 6 + (3 * 32'hB71B) / 64);
        wr(8'h40, 32'h3);
        rd(8'h40, v); check("R11 valid cleared", v, 0);
    endtask

    task automatic t_unmapped;
        logic [31:0] v;
        rd(8'h44, v); check("R12 unmapped 0x44", v, 0);
        rd(8'h80, v); check("R12 unmapped 0x80", v, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_count;
        t_reach;
        t_sync_ignored;
        t_soft;
        t_hard;
        t_unmapped;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule